// File: doc/BRIEF.md
# Stereo PDM Capture and Decimator

This block takes a single-wire, two-channel 1-bit pulse-density stream and turns it into two 20-bit signed PCM streams. Its clock is the PDM clock. The data wire is sampled on both clock edges. The bit taken on the rising edge belongs to the left channel. The bit taken on the falling edge belongs to the right channel and is moved into the rising-edge domain before it is used.

Each channel runs through a four-stage integrator/comb (CIC) filter that decimates by exactly 64, so one word per channel comes out every 64 clock periods. The input bit is mapped to +1 or -1. The full-precision result is shifted down to 20 bits and clamped at the signed limits.

A one-cycle valid strobe marks the cycle in which both channel words update together. The first four decimation points after reset are not flagged valid while the filter history fills. Dropping the enable input freezes the whole block in place.

Top module: `pdm_stereo_decim`

## Requirements
- R1: While reset is asserted, and after its release until the first valid strobe, both PCM outputs read 0 and the valid strobe is low.
- R2: With enable held high, the valid strobe is high for exactly one clock cycle, and consecutive strobes are exactly 64 rising edges apart.
- R3: The first four decimation points after reset produce no strobe. With enable high from reset release, the first strobe is seen right after the 320th rising edge.
- R4: The left word is built only from bits sampled on rising edges and the right word only from bits sampled on falling edges: a 1 on every rising edge with a 0 on every falling edge drives left to its positive limit and right to its negative limit, and the swapped pattern does the reverse.
- R5: A PDM 1 counts as +1 and a PDM 0 counts as -1. A constant 0 on both channels settles at -524288 on both words (two's complement, 20 bits).
- R6: A constant 1 on both channels would scale to +524288 and is clamped to +524287 on both words.
- R7: A channel whose bits alternate 1,0,1,0 on its own edge settles at exactly 0.
- R8: A channel whose bits repeat the pattern 1,0,0,0 on its own edge settles at exactly -262144 (average density -0.5 scaled to 20 bits).
- R9: While enable is low, no valid strobe occurs and both PCM words hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PDM clock; all filter logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low freezes capture, filter and strobe |
| pdm_dat | input | 1 | Shared PDM data wire, left on rising edge, right on falling edge |
| left_pcm | output | 20 | Left channel signed PCM word |
| right_pcm | output | 20 | Right channel signed PCM word |
| pcm_valid | output | 1 | One-cycle strobe when both words update |

## Verification
A corrupted integrator or comb delay word shows up within one or two output frames as a settled value that is off from the exact levels expected for constant, alternating and quarter-density patterns. Those levels are exact because the filter has nulls at those pattern rates. A swapped edge assignment shows up as soon as the two channels are fed opposite constants. A wrong phase or fill counter moves the first strobe away from edge 320 or breaks the 64-edge spacing, and this is seen on the first or second strobe.

// File: rtl/pdm_stereo_decim.sv
module pdm_stereo_decim #(
  parameter int RATE_LOG2 = 6,
  parameter int STAGES    = 4,
  parameter int OUT_W     = 20,
  parameter int FILL      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pdm_dat,
  output logic [OUT_W-1:0] left_pcm,
  output logic [OUT_W-1:0] right_pcm,
  output logic             pcm_valid
);
  localparam int ACC_W  = STAGES * RATE_LOG2 + 2;
  localparam int SHIFT  = ACC_W - OUT_W - 1;
  localparam int FILL_W = $clog2(FILL + 1);
  localparam logic signed [ACC_W-1:0] PMAX = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] PMIN = -PMAX - 1;

  logic                   fall_bit;
  logic [1:0]             smp;
  logic [RATE_LOG2-1:0]   phase;
  logic [FILL_W-1:0]      fill_cnt;
  logic signed [ACC_W-1:0] integ [2][STAGES];
  logic signed [ACC_W-1:0] dly   [2][STAGES];
  logic signed [ACC_W-1:0] comb  [2][STAGES+1];
  logic signed [ACC_W-1:0] scl   [2];
  logic [OUT_W-1:0]        sat   [2];
  logic signed [ACC_W-1:0] xin   [2];

  wire dec_pt = en && (phase == {RATE_LOG2{1'b1}});

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n)  fall_bit <= 1'b0;
    else if (en) fall_bit <= pdm_dat;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      xin[c] = {{(ACC_W-1){~smp[c]}}, 1'b1};
      comb[c][0] = integ[c][STAGES-1];
      for (int s = 0; s < STAGES; s++) comb[c][s+1] = comb[c][s] - dly[c][s];
      scl[c] = comb[c][STAGES] >>> SHIFT;
      if (scl[c] > PMAX)      sat[c] = PMAX[OUT_W-1:0];
      else if (scl[c] < PMIN) sat[c] = PMIN[OUT_W-1:0];
      else                    sat[c] = scl[c][OUT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp       <= '0;
      phase     <= '0;
      fill_cnt  <= '0;
      left_pcm  <= '0;
      right_pcm <= '0;
      pcm_valid <= 1'b0;
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < STAGES; s++) begin
          integ[c][s] <= '0;
          dly[c][s]   <= '0;
        end
    end else begin
      pcm_valid <= 1'b0;
      if (en) begin
        smp   <= {fall_bit, pdm_dat};
        phase <= phase + 1'b1;
        for (int c = 0; c < 2; c++) begin
          integ[c][0] <= integ[c][0] + xin[c];
          for (int s = 1; s < STAGES; s++) integ[c][s] <= integ[c][s] + integ[c][s-1];
        end
      end
      if (dec_pt) begin
        for (int c = 0; c < 2; c++)
          for (int s = 0; s < STAGES; s++) dly[c][s] <= comb[c][s];
        if (fill_cnt != FILL_W'(FILL)) fill_cnt <= fill_cnt + 1'b1;
        else begin
          pcm_valid <= 1'b1;
          left_pcm  <= sat[0];
          right_pcm <= sat[1];
        end
      end
    end
  end

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid);
  assert_strobe_needs_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |-> fill_cnt == FILL_W'(FILL));
  assert_no_strobe_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |-> $past(en));
  assert_hold_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(left_pcm) && $stable(right_pcm)));
  assert_words_move_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_valid |-> ($stable(left_pcm) && $stable(right_pcm)));
endmodule

// File: tb/pdm_stereo_decim_tb.sv
`timescale 1ns/1ps
module pdm_stereo_decim_tb;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, pdm_dat = 1'b0;
  logic [19:0] left_pcm, right_pcm;
  logic pcm_valid;
  int n_run = 0, n_fail = 0;
  int lmode = 0, rmode = 0;
  int lph = 0, rph = 0;

  localparam int PMAX = 524287;
  localparam int PMIN = -524288;

  pdm_stereo_decim u_dut (.clk(clk), .rst_n(rst_n), .en(en), .pdm_dat(pdm_dat),
    .left_pcm(left_pcm), .right_pcm(right_pcm), .pcm_valid(pcm_valid));

  always #10 clk = ~clk;

  function automatic logic pat(input int mode, input int ph);
    case (mode)
      0: return 1'b0;
      1: return 1'b1;
      2: return (ph % 2) == 0;
      default: return (ph % 4) == 0;
    endcase
  endfunction

  always @(posedge clk) begin
    #5 pdm_dat = pat(rmode, rph);
    rph++;
  end
  always @(negedge clk) begin
    #5 pdm_dat = pat(lmode, lph);
    lph++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sx(input logic [19:0] v);
    return int'($signed(v));
  endfunction

  task automatic wait_valid();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (pcm_valid) return;
    end
  endtask

  task automatic do_reset();
    en = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_and_first();
    int n;
    lmode = 1; rmode = 1;
    do_reset();
    chk(sx(left_pcm) == 0 && sx(right_pcm) == 0, "R1 words in reset", sx(left_pcm), 0);
    chk(pcm_valid == 1'b0, "R1 strobe in reset", pcm_valid, 0);
    rst_n = 1'b1;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (pcm_valid) break;
      if (n == 300) chk(sx(left_pcm) == 0 && sx(right_pcm) == 0, "R1 words before first strobe", sx(left_pcm), 0);
    end
    chk(n == 320, "R3 first strobe edge", n, 320);
  endtask

  task automatic t_spacing();
    int n;
    wait_valid();
    @(negedge clk);
    chk(pcm_valid == 1'b0, "R2 strobe width", pcm_valid, 0);
    n = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      n++;
      if (pcm_valid) break;
    end
    chk(n == 64, "R2 strobe spacing", n, 64);
  endtask

  task automatic t_pattern(input int lm, input int rm, input int el, input int er, input string tag);
    lmode = lm; rmode = rm;
    repeat (8) wait_valid();
    wait_valid();
    chk(sx(left_pcm) == el, {tag, " left"}, sx(left_pcm), el);
    chk(sx(right_pcm) == er, {tag, " right"}, sx(right_pcm), er);
  endtask

  task automatic t_freeze();
    int l0, r0, bad;
    wait_valid();
    l0 = sx(left_pcm); r0 = sx(right_pcm);
    lmode = 0; rmode = 1;
    en = 1'b0;
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pcm_valid) bad++;
    end
    chk(bad == 0, "R9 no strobe while disabled", bad, 0);
    chk(sx(left_pcm) == l0, "R9 left held", sx(left_pcm), l0);
    chk(sx(right_pcm) == r0, "R9 right held", sx(right_pcm), r0);
    en = 1'b1;
    t_pattern(0, 1, PMIN, PMAX, "R9 resume");
  endtask

  initial begin
    #(20ns * 190000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_and_first();
    t_spacing();
    t_pattern(1, 1, PMAX, PMAX, "R6 clamp ones");
    t_pattern(0, 0, PMIN, PMIN, "R5 all zeros");
    t_pattern(1, 0, PMAX, PMIN, "R4 left ones right zeros");
    t_pattern(0, 1, PMIN, PMAX, "R4 left zeros right ones");
    t_pattern(2, 1, 0, PMAX, "R7 left alternating");
    t_pattern(1, 2, PMAX, 0, "R7 right alternating");
    t_pattern(3, 2, -262144, 0, "R8 left quarter");
    t_pattern(0, 3, PMIN, -262144, "R8 right quarter");
    t_freeze();
    t_spacing();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule